// File: doc/BRIEF.md
# Serial Audio Output Clock Generator

This block produces the bit clock and left/right word-select signals for a group of serial audio output ports. In master mode it derives them by dividing an oversampled audio master clock. The master clock runs at 256 or 384 times the sample rate. Every channel slot is 32 bit clocks long, so a frame is 64 bit clocks. The main clock pair drives the shared ports at normal or double rate. A second clock pair serves the fourth port when that port runs at quad rate. Frame-start strobes and bit indices are provided so that the data serialisers stay locked to the generated clocks. In slave mode the generators stop, and an externally supplied bit clock is passed to the second pair's clock output.

The divider logic runs on `clk_i`, a tick clock at twice the audio master clock, which comes from an external doubler. Every ratio, including the 1.5× master-clock period needed for quad rate from a 384× source, is therefore a whole number of ticks. A configuration change made while the clocks are running waits for the end of the current frame. The outputs are then held low for a fixed number of ticks, and both generators restart from bit 0. A separate tap gives a gated or divided copy of a system clock.

Top module: `aclk_outgen`

## Requirements
- R1: While `rst_ni` is low, and until the 4th rising edge of `clk_i` after its release, all clock, word-select and strobe outputs are low. The first main frame strobe is seen after that 4th edge (`HOLD_CYC` = 4).
- R2: The main bit clock period in `clk_i` ticks is 8 for a 256× source at normal rate, 4 for 256× at double rate, 12 for 384× at normal rate and 6 for 384× at double rate. The encoding is `ovs384_i` 0 for 256× and 1 for 384×, and `dbl_i` 1 for double rate. Each period starts with a low half that is exactly half of the period.
- R3: Word select is low during bits 0 to 31 of a frame (left) and high during bits 32 to 63 (right). It changes only together with a falling edge of the bit clock.
- R4: `frame_o` is high for exactly one tick, the first tick of the low half of bit 0. `bit_o` holds the index of the bit period in progress and advances at each falling edge, wrapping from 63 to 0.
- R5: With `quad_i`=1 in master mode, `qbclk_o` has a period of 2 ticks (1 low, 1 high) for 256× and 3 ticks (1 low, 2 high) for 384×. `qlrck_o`, `qframe_o` and `qbit_o` follow R3 and R4 at that rate. With `quad_i`=0, `qbclk_o` and `qlrck_o` stay low.
- R6: When the quad pair is enabled, every main frame strobe coincides with a quad frame strobe.
- R7: With `slave_i`=1 in effect, `qbclk_o` follows `ext_bclk_i` combinationally. `bclk_o`, `lrck_o`, `qlrck_o`, `frame_o` and `qframe_o` stay low.
- R8: A configuration change made while the generators run has no effect until the last tick of the current main frame. After that tick, the outputs stay low and the strobes silent for 4 ticks. The next tick carries a frame strobe at the new rate.
- R9: `sys_div_o` is low for `sys_sel_i`=0. It equals `clk_sys_i` for 1, is `clk_sys_i` divided by 2 for 2, and is divided by 4 for 3.
- R10: A configuration change made while the generators are stopped (slave mode or hold) is taken at the next tick. The main frame strobe then appears on the 5th tick after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Tick clock, twice the audio master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ovs384_i | input | 1 | Master clock ratio: 0 = 256×, 1 = 384× |
| dbl_i | input | 1 | Main pair at double rate |
| quad_i | input | 1 | Enable quad-rate second pair |
| slave_i | input | 1 | Slave mode, generators stopped |
| ext_bclk_i | input | 1 | External bit clock used in slave mode |
| clk_sys_i | input | 1 | System clock to be tapped |
| sys_sel_i | input | 2 | System tap: 0 off, 1 ÷1, 2 ÷2, 3 ÷4 |
| bclk_o | output | 1 | Main bit clock |
| lrck_o | output | 1 | Main word select |
| frame_o | output | 1 | Main frame-start strobe |
| bit_o | output | 6 | Main bit index in frame |
| qbclk_o | output | 1 | Second pair bit clock (quad rate, or slave copy) |
| qlrck_o | output | 1 | Second pair word select |
| qframe_o | output | 1 | Second pair frame-start strobe |
| qbit_o | output | 6 | Second pair bit index in frame |
| sys_div_o | output | 1 | Gated or divided system clock |

## Verification
The assertions assume that the configuration inputs change only between rising edges of `clk_i`. They also assume that a frame boundary, once reached, is not overtaken by a further change in the same tick. The bench keeps to this by driving every input just after a falling edge of `clk_i` and sampling there as well. The cross-pair alignment checks assume that both generators leave a hold in the same tick, which holds as long as quad enable changes only through the sequencer. `ext_bclk_i` is toggled only in slave mode, where it cannot disturb the dividers.

// File: rtl/aclk_pkg.sv
package aclk_pkg;

    // Applied clocking configuration
    typedef struct packed {
        logic slave;    // generators stopped, external bit clock passed on
        logic quad;     // second pair runs at quad rate
        logic dbl;      // main pair at double rate
        logic ovs384;   // master clock is 384x (else 256x)
    } clk_cfg_t;

endpackage

// File: rtl/aclk_bitdiv.sv
module aclk_bitdiv #(
    parameter int CNT_W     = 4,
    parameter int SLOT_BITS = 32
) (
    input  logic                              clk_i,
    input  logic                              rst_ni,
    input  logic                              clr_i,
    input  logic [CNT_W-1:0]                  lo_len_i,
    input  logic [CNT_W-1:0]                  hi_len_i,
    output logic                              bclk_o,
    output logic                              lrck_o,
    output logic [$clog2(2*SLOT_BITS)-1:0]    bit_o,
    output logic                              frame_start_o,
    output logic                              frame_end_o
);

    localparam int FRAME_BITS = 2 * SLOT_BITS;
    localparam int BIT_W      = $clog2(FRAME_BITS);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             bclk;
        logic             lrck;
        logic [BIT_W-1:0] bitn;
    } div_state_t;

    div_state_t       st_d, st_q;
    logic [CNT_W-1:0] phase_len;
    logic             phase_last;

    always_comb begin
        phase_len  = st_q.bclk ? hi_len_i : lo_len_i;
        phase_last = (st_q.cnt == phase_len - CNT_W'(1));
        st_d       = st_q;
        if (clr_i) begin
            st_d = '0;
        end else if (phase_last) begin
            st_d.cnt  = '0;
            st_d.bclk = !st_q.bclk;
            if (st_q.bclk) begin
                st_d.bitn = (st_q.bitn == BIT_W'(FRAME_BITS - 1)) ? '0 : st_q.bitn + 1'b1;
                st_d.lrck = (st_d.bitn >= BIT_W'(SLOT_BITS));
            end
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign bclk_o        = st_q.bclk;
    assign lrck_o        = st_q.lrck;
    assign bit_o         = st_q.bitn;
    assign frame_start_o = !clr_i && !st_q.bclk && (st_q.cnt == '0) && (st_q.bitn == '0);
    assign frame_end_o   = st_q.bclk && phase_last && (st_q.bitn == BIT_W'(FRAME_BITS - 1));

    // R3
    ws_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(st_q.lrck) |-> $fell(st_q.bclk));

    // R4
    frame_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_end_o |=> (st_q.bitn == '0) && !st_q.bclk);

endmodule

// File: rtl/aclk_seq.sv
module aclk_seq import aclk_pkg::*; #(
    parameter int HOLD_CYC = 4
) (
    input  logic     clk_i,
    input  logic     rst_ni,
    input  clk_cfg_t cfg_i,
    input  logic     frame_end_i,
    output clk_cfg_t cfg_o,
    output logic     clr_o
);

    localparam int HOLD_W = $clog2(HOLD_CYC + 1);

    typedef struct packed {
        clk_cfg_t          cfg;
        logic [HOLD_W-1:0] hold;
    } seq_state_t;

    seq_state_t st_d, st_q;
    logic       running;
    logic       apply;

    always_comb begin
        running = (st_q.hold == '0) && !st_q.cfg.slave;
        apply   = (cfg_i != st_q.cfg) && (!running || frame_end_i);
        st_d    = st_q;
        if (apply) begin
            st_d.cfg  = cfg_i;
            st_d.hold = HOLD_W'(HOLD_CYC);
        end else if (st_q.hold != '0) begin
            st_d.hold = st_q.hold - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.cfg  <= '0;
            st_q.hold <= HOLD_W'(HOLD_CYC);
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_o = st_q.cfg;
    assign clr_o = !running || apply;

    // R8
    cfg_at_boundary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(st_q.cfg) |-> $past(!running || frame_end_i));

    // R8
    hold_after_apply_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        apply |=> clr_o);

endmodule

// File: rtl/aclk_sysdiv.sv
module aclk_sysdiv (
    input  logic       clk_sys_i,
    input  logic       rst_ni,
    input  logic [1:0] sel_i,
    output logic       div_o
);

    logic [1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q + 2'd1;
    end

    always_ff @(posedge clk_sys_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    always_comb begin
        case (sel_i)
            2'd1:    div_o = clk_sys_i;
            2'd2:    div_o = cnt_q[0];
            2'd3:    div_o = cnt_q[1];
            default: div_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/aclk_outgen.sv
module aclk_outgen import aclk_pkg::*; #(
    parameter int SLOT_BITS = 32,
    parameter int OVS_LO    = 256,
    parameter int OVS_HI    = 384,
    parameter int HOLD_CYC  = 4
) (
    input  logic                             clk_i,
    input  logic                             rst_ni,
    input  logic                             ovs384_i,
    input  logic                             dbl_i,
    input  logic                             quad_i,
    input  logic                             slave_i,
    input  logic                             ext_bclk_i,
    input  logic                             clk_sys_i,
    input  logic [1:0]                       sys_sel_i,
    output logic                             bclk_o,
    output logic                             lrck_o,
    output logic                             frame_o,
    output logic [$clog2(2*SLOT_BITS)-1:0]   bit_o,
    output logic                             qbclk_o,
    output logic                             qlrck_o,
    output logic                             qframe_o,
    output logic [$clog2(2*SLOT_BITS)-1:0]   qbit_o,
    output logic                             sys_div_o
);

    localparam int BIT_W  = $clog2(2 * SLOT_BITS);
    localparam int PER_LO = OVS_LO / SLOT_BITS;   // ticks per bit, normal rate
    localparam int PER_HI = OVS_HI / SLOT_BITS;
    localparam int CNT_W  = $clog2(PER_HI + 1);
    localparam int LANES  = 2;                    // 0: main pair, 1: quad pair

    clk_cfg_t         cfg_in, cfg_q;
    logic             seq_clr;
    logic [CNT_W-1:0] base_per;
    logic [CNT_W-1:0] per      [LANES];
    logic [CNT_W-1:0] lo_len   [LANES];
    logic [CNT_W-1:0] hi_len   [LANES];
    logic [LANES-1:0] clr, bclk, lrck, fstart, fend;
    logic [BIT_W-1:0] bitn     [LANES];

    always_comb begin
        cfg_in.slave  = slave_i;
        cfg_in.quad   = quad_i;
        cfg_in.dbl    = dbl_i;
        cfg_in.ovs384 = ovs384_i;
    end

    aclk_seq #(.HOLD_CYC(HOLD_CYC)) u_seq (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .cfg_i       (cfg_in),
        .frame_end_i (fend[0]),
        .cfg_o       (cfg_q),
        .clr_o       (seq_clr)
    );

    always_comb begin
        base_per = cfg_q.ovs384 ? CNT_W'(PER_HI) : CNT_W'(PER_LO);
        per[0]   = cfg_q.dbl ? (base_per >> 1) : base_per;
        per[1]   = base_per >> 2;
        clr[0]   = seq_clr;
        clr[1]   = seq_clr || !cfg_q.quad;
        for (int i = 0; i < LANES; i++) begin
            lo_len[i] = per[i] >> 1;
            hi_len[i] = per[i] - lo_len[i];
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        aclk_bitdiv #(.CNT_W(CNT_W), .SLOT_BITS(SLOT_BITS)) u_div (
            .clk_i         (clk_i),
            .rst_ni        (rst_ni),
            .clr_i         (clr[g]),
            .lo_len_i      (lo_len[g]),
            .hi_len_i      (hi_len[g]),
            .bclk_o        (bclk[g]),
            .lrck_o        (lrck[g]),
            .bit_o         (bitn[g]),
            .frame_start_o (fstart[g]),
            .frame_end_o   (fend[g])
        );
    end

    aclk_sysdiv u_sysdiv (
        .clk_sys_i (clk_sys_i),
        .rst_ni    (rst_ni),
        .sel_i     (sys_sel_i),
        .div_o     (sys_div_o)
    );

    assign bclk_o   = !cfg_q.slave && bclk[0];
    assign lrck_o   = !cfg_q.slave && lrck[0];
    assign frame_o  = fstart[0];
    assign bit_o    = bitn[0];
    assign qbclk_o  = cfg_q.slave ? ext_bclk_i : (cfg_q.quad && bclk[1]);
    assign qlrck_o  = !cfg_q.slave && cfg_q.quad && lrck[1];
    assign qframe_o = fstart[1];
    assign qbit_o   = bitn[1];

    // R6
    frames_aligned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fstart[0] && cfg_q.quad) |-> fstart[1]);

    // R6
    ends_aligned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fend[0] && cfg_q.quad && !seq_clr) |-> fend[1]);

endmodule

// File: tb/test_aclk_outgen.sv
`timescale 1ns/1ps
module test_aclk_outgen;

    logic       clk = 1'b0;
    logic       clk_sys = 1'b0;
    logic       rst_n;
    logic [3:0] cfg_v;          // {slave, quad, dbl, ovs384}
    logic       ext_bclk;
    logic [1:0] sys_sel;
    logic       bclk, lrck, frame, qbclk, qlrck, qframe, sys_div;
    logic [5:0] bitn, qbitn;
    int         checks = 0;
    int         errors = 0;

    always #2.5 clk = ~clk;         // 200 MHz tick clock
    always #3.5 clk_sys = ~clk_sys;

    aclk_outgen i_aclk_outgen (
        .clk_i(clk), .rst_ni(rst_n),
        .ovs384_i(cfg_v[0]), .dbl_i(cfg_v[1]), .quad_i(cfg_v[2]), .slave_i(cfg_v[3]),
        .ext_bclk_i(ext_bclk), .clk_sys_i(clk_sys), .sys_sel_i(sys_sel),
        .bclk_o(bclk), .lrck_o(lrck), .frame_o(frame), .bit_o(bitn),
        .qbclk_o(qbclk), .qlrck_o(qlrck), .qframe_o(qframe), .qbit_o(qbitn),
        .sys_div_o(sys_div)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_fs();
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (frame !== 1'b1 && n < 2000);
        chk(frame === 1'b1, "R4 frame strobe found", n, 0);
    endtask

    // Caller is positioned on the frame-strobe sample (n = 0)
    task automatic check_frame(input int per, input bit q, input string req);
        int lo = per / 2;
        int bad_clk = 0, bad_ws = 0, bad_idx = 0;
        for (int n = 0; n < 64 * per; n++) begin
            logic c, w, f;
            logic [5:0] b;
            if (n > 0) @(negedge clk);
            c = q ? qbclk : bclk;
            w = q ? qlrck : lrck;
            f = q ? qframe : frame;
            b = q ? qbitn : bitn;
            if (c !== ((n % per) >= lo)) bad_clk++;
            if (w !== ((n / per) >= 32)) bad_ws++;
            if (b !== 6'(n / per) || f !== (n == 0)) bad_idx++;
        end
        chk(bad_clk == 0, {req, " R2 R5 bit clock shape"}, bad_clk, 0);
        chk(bad_ws == 0,  {req, " R3 word select"}, bad_ws, 0);
        chk(bad_idx == 0, {req, " R4 bit index and strobe"}, bad_idx, 0);
    endtask

    task automatic change_during(input logic [3:0] nc, input int old_per);
        int lo = old_per / 2;
        int bad = 0;
        wait_fs();
        for (int n = 0; n < 64 * old_per; n++) begin
            if (n > 0) @(negedge clk);
            if (bclk !== ((n % old_per) >= lo)) bad++;
            if (n == 100) cfg_v = nc;
        end
        chk(bad == 0, "R8 old rate kept to frame end", bad, 0);
        bad = 0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (bclk !== 1'b0 || frame !== 1'b0 || lrck !== 1'b0) bad++;
        end
        chk(bad == 0, "R8 outputs held low", bad, 0);
        @(negedge clk);
        chk(frame === 1'b1, "R8 restart strobe", int'(frame), 1);
    endtask

    task automatic t_reset();
        int bad = 0;
        rst_n = 1'b0;
        cfg_v = 4'b0000;
        ext_bclk = 1'b0;
        sys_sel = 2'd0;
        repeat (5) @(negedge clk);
        chk(bclk === 0 && lrck === 0 && frame === 0 && qbclk === 0, "R1 in reset", int'(bclk), 0);
        rst_n = 1'b1;
        for (int k = 1; k <= 3; k++) begin
            @(negedge clk);
            if (frame !== 0 || bclk !== 0 || lrck !== 0 || qbclk !== 0 || qlrck !== 0) bad++;
        end
        chk(bad == 0, "R1 quiet during hold", bad, 0);
        @(negedge clk);
        chk(frame === 1'b1, "R1 first strobe on 4th edge", int'(frame), 1);
        check_frame(8, 1'b0, "256 normal");
    endtask

    task automatic t_quad_idle();
        int bad = 0;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (qbclk !== 0 || qlrck !== 0 || qframe !== 0) bad++;
        end
        chk(bad == 0, "R5 quad pair idle", bad, 0);
    endtask

    task automatic t_rates();
        change_during(4'b0001, 8);          // 384 normal
        check_frame(12, 1'b0, "384 normal");
        change_during(4'b0010, 12);         // 256 double
        check_frame(4, 1'b0, "256 double");
        change_during(4'b0011, 4);          // 384 double
        check_frame(6, 1'b0, "384 double");
    endtask

    task automatic t_quad();
        change_during(4'b0111, 6);          // quad, 384 double
        chk(qframe === 1'b1, "R6 quad strobe with main strobe", int'(qframe), 1);
        check_frame(3, 1'b1, "quad 384");
        change_during(4'b0110, 6);          // quad, 256 double
        chk(qframe === 1'b1, "R6 quad strobe with main strobe", int'(qframe), 1);
        check_frame(2, 1'b1, "quad 256");
        wait_fs();
        chk(qframe === 1'b1, "R6 alignment next frame", int'(qframe), 1);
    endtask

    task automatic t_slave();
        int bad = 0;
        wait_fs();
        cfg_v = 4'b1000;
        repeat (64 * 4 + 8) @(negedge clk);
        for (int k = 0; k < 8; k++) begin
            ext_bclk = k[0];
            #1;
            if (qbclk !== ext_bclk) bad++;
            @(negedge clk);
            if (bclk !== 0 || lrck !== 0 || qlrck !== 0 || frame !== 0 || qframe !== 0) bad++;
        end
        chk(bad == 0, "R7 slave pass-through", bad, 0);
        ext_bclk = 1'b1;
        #1;
        chk(qbclk === 1'b1, "R7 copy high", int'(qbclk), 1);
        ext_bclk = 1'b0;
        #1;
        chk(qbclk === 1'b0, "R7 copy low", int'(qbclk), 0);
    endtask

    task automatic t_slave_exit();
        int bad = 0;
        @(negedge clk);
        cfg_v = 4'b0000;
        for (int k = 1; k <= 4; k++) begin
            @(negedge clk);
            if (frame !== 0 || bclk !== 0) bad++;
        end
        chk(bad == 0, "R10 quiet before restart", bad, 0);
        @(negedge clk);
        chk(frame === 1'b1, "R10 strobe on 5th edge", int'(frame), 1);
        check_frame(8, 1'b0, "R10 after slave");
    endtask

    task automatic t_sysdiv();
        int bad = 0;
        int chg = 0;
        logic prev;
        sys_sel = 2'd0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk_sys); #1;
            if (sys_div !== 0) bad++;
        end
        chk(bad == 0, "R9 tap off", bad, 0);
        sys_sel = 2'd1;
        bad = 0;
        for (int k = 0; k < 4; k++) begin
            @(posedge clk_sys); #1;
            if (sys_div !== 1) bad++;
            @(negedge clk_sys); #1;
            if (sys_div !== 0) bad++;
        end
        chk(bad == 0, "R9 divide by 1", bad, 0);
        sys_sel = 2'd2;
        @(negedge clk_sys); #1;
        prev = sys_div;
        for (int k = 0; k < 32; k++) begin
            @(negedge clk_sys); #1;
            if (sys_div !== prev) chg++;
            prev = sys_div;
        end
        chk(chg == 32, "R9 divide by 2", chg, 32);
        sys_sel = 2'd3;
        chg = 0;
        @(negedge clk_sys); #1;
        prev = sys_div;
        for (int k = 0; k < 32; k++) begin
            @(negedge clk_sys); #1;
            if (sys_div !== prev) chg++;
            prev = sys_div;
        end
        chk(chg == 16, "R9 divide by 4", chg, 16);
    endtask

    initial begin
        #500000;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_quad_idle();
        t_rates();
        t_quad();
        t_slave();
        t_slave_exit();
        t_sysdiv();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule